// File: doc/BRIEF.md
# Vertical Link Check and Shift-Repair Group

This block sits between the core logic of a stacked die and its vertical through-silicon signal links. Links are organised in groups. Each group carries four logical signals over six physical links, and no link is reserved as a spare. Command, address and data bits all travel through the same kind of group.

In check mode, the result of an external open/short test is captured into one latch per link. The latches form a single serial chain, so a tester can shift the pass/fail pattern out one bit per clock. This tells the tester which link positions failed.

In repair mode, a failure map read from fuses is loaded into a register. That map steers each group's signals. Logical signal i is carried on the i-th working link, counting upward from link 0. Every signal at or above a broken link therefore moves to the next neighbour. The same steering is applied on the sending side and on the receiving side, so the logical bits line up again at the far end. A group with more failures than spare positions raises its own unrepairable flag.

Top module: `tsvr_top`

## Requirements
- R1: A synchronous active-high reset clears every result latch and the loaded failure map. After reset, scan_out is 0, no unrepairable flag is set, and group signal i drives link i.
- R2: When capture_en is high at a clock edge, every result latch loads the matching bit of open_short_fail (1 = failed link). Capture takes priority over shifting.
- R3: When scan_en is high and capture_en is low, the chain moves one position per clock. scan_out always shows the latch of chain position 0, which is link 0 of group 0. Positions follow link number, and group g, link p sits at position g*6+p. scan_in enters the highest position, so a full-length shift reads the links out in ascending order and refills the chain with the shifted-in bits.
- R4: With scan_en and capture_en both low, the result latches hold their value.
- R5: fuse_load high at a clock edge loads fuse_fail_map (bit g*6+p = 1 marks group g, link p as broken). The new routing takes effect from the next cycle. While fuse_load is low, changes on fuse_fail_map have no effect.
- R6: In a group with no marked failures, signal i (tx_sig bit g*4+i) drives link i, and links 4 and 5 are driven 0.
- R7: With marked failures, signal i of a group drives the i-th unmarked link in ascending link order. Marked links and unused links are driven 0.
- R8: The receive side uses the same steering. For any map with at most two failures in a group, and faulty links confined to the marked ones, rx_sig equals tx_sig for that group.
- R9: unrepairable[g] is high exactly when more than two links of group g are marked. In that state the signals that have no working link left read 0 on rx_sig.
- R10: Groups are independent. The map or data of one group never changes the link drive, received signals or flag of another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Load test results into the result latches |
| open_short_fail | input | NGRP*6 | Per-link open/short test result, 1 = fail |
| scan_en | input | 1 | Shift the result chain by one position |
| scan_in | input | 1 | Serial input to the highest chain position |
| scan_out | output | 1 | Serial output, chain position 0 |
| fuse_load | input | 1 | Load the failure map from fuses |
| fuse_fail_map | input | NGRP*6 | Fuse failure map, 1 = broken link |
| tx_sig | input | NGRP*4 | Logical signals to send |
| tsv_drive | output | NGRP*6 | Values driven onto the physical links |
| tsv_sense | input | NGRP*6 | Values received from the physical links |
| rx_sig | output | NGRP*4 | Logical signals recovered at the receiver |
| unrepairable | output | NGRP | Per-group flag: more than two broken links |

## Verification
A corrupted result latch appears on scan_out during the serial readout. It shows up in the cycle its chain position reaches position 0, so the position of the error in the bit stream names the bad latch. A wrong failure-map bit or a wrong steering choice shows up one cycle after fuse_load. It appears either as a nonzero drive on a marked link or as rx_sig differing from tx_sig in a loopback that inverts the broken links. All 64 maps of one group are swept this way with several data patterns. Meanwhile the other group stays on a fixed map, and its outputs are checked to stay unchanged.

// File: rtl/tsvr_pkg.sv
`timescale 1ns/1ps
package tsvr_pkg;
    localparam int GRP_SIG = 4;
    localparam int GRP_PHY = 6;
    localparam int SPARE   = GRP_PHY - GRP_SIG;
    localparam int IDXW    = $clog2(GRP_PHY);
    localparam int SLW     = $clog2(GRP_SIG);

    typedef struct packed {
        logic            ok;
        logic [IDXW-1:0] src;
    } lane_t;

    typedef lane_t [GRP_SIG-1:0] lane_map_t;

    // Signal i takes the i-th unbroken link, lowest link first.
    function automatic lane_map_t plan_lanes(input logic [GRP_PHY-1:0] bad);
        lane_map_t m;
        int        slot;
        m    = '0;
        slot = 0;
        for (int p = 0; p < GRP_PHY; p++) begin
            if (!bad[p] && slot < GRP_SIG) begin
                m[slot[SLW-1:0]].ok  = 1'b1;
                m[slot[SLW-1:0]].src = IDXW'(p);
                slot = slot + 1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/tsvr_scan_chain.sv
`timescale 1ns/1ps
module tsvr_scan_chain #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_en,
    input  logic [N-1:0] result,
    input  logic         scan_en,
    input  logic         scan_in,
    output logic [N-1:0] chain_q,
    output logic         scan_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (capture_en) begin
            chain_q <= result;
        end else if (scan_en) begin
            chain_q <= {scan_in, chain_q[N-1:1]};
        end
    end

    assign scan_out = chain_q[0];
endmodule

// File: rtl/tsvr_tx_steer.sv
`timescale 1ns/1ps
module tsvr_tx_steer
    import tsvr_pkg::*;
(
    input  lane_map_t            map,
    input  logic [GRP_SIG-1:0]   sig,
    output logic [GRP_PHY-1:0]   link
);
    always_comb begin
        link = '0;
        for (int i = 0; i < GRP_SIG; i++) begin
            if (map[i].ok) link[map[i].src] = sig[i];
        end
    end
endmodule

// File: rtl/tsvr_rx_steer.sv
`timescale 1ns/1ps
module tsvr_rx_steer
    import tsvr_pkg::*;
(
    input  lane_map_t            map,
    input  logic [GRP_PHY-1:0]   link,
    output logic [GRP_SIG-1:0]   sig
);
    always_comb begin
        for (int i = 0; i < GRP_SIG; i++) begin
            sig[i] = map[i].ok ? link[map[i].src] : 1'b0;
        end
    end
endmodule

// File: rtl/tsvr_group.sv
`timescale 1ns/1ps
module tsvr_group
    import tsvr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fuse_load,
    input  logic [GRP_PHY-1:0] fuse_bits,
    input  logic [GRP_SIG-1:0] sig_in,
    output logic [GRP_PHY-1:0] link_out,
    input  logic [GRP_PHY-1:0] link_in,
    output logic [GRP_SIG-1:0] sig_out,
    output logic               unrep,
    output logic [GRP_PHY-1:0] bad_q
);
    lane_map_t lanes;

    always_ff @(posedge clk) begin
        if (rst)            bad_q <= '0;
        else if (fuse_load) bad_q <= fuse_bits;
    end

    assign lanes = plan_lanes(bad_q);
    assign unrep = ($countones(bad_q) > SPARE);

    tsvr_tx_steer u_tx (.map(lanes), .sig(sig_in), .link(link_out));
    tsvr_rx_steer u_rx (.map(lanes), .link(link_in), .sig(sig_out));
endmodule

// File: rtl/tsvr_top.sv
`timescale 1ns/1ps
module tsvr_top
    import tsvr_pkg::*;
#(
    parameter int NGRP = 2,
    localparam int NT  = NGRP * GRP_PHY,
    localparam int NS  = NGRP * GRP_SIG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture_en,
    input  logic [NT-1:0] open_short_fail,
    input  logic          scan_en,
    input  logic          scan_in,
    output logic          scan_out,
    input  logic          fuse_load,
    input  logic [NT-1:0] fuse_fail_map,
    input  logic [NS-1:0] tx_sig,
    output logic [NT-1:0] tsv_drive,
    input  logic [NT-1:0] tsv_sense,
    output logic [NS-1:0] rx_sig,
    output logic [NGRP-1:0] unrepairable
);
    logic [NT-1:0] scan_q;
    logic [NT-1:0] bad_q;

    tsvr_scan_chain #(.N(NT)) u_chain (
        .clk(clk), .rst(rst), .capture_en(capture_en), .result(open_short_fail),
        .scan_en(scan_en), .scan_in(scan_in), .chain_q(scan_q), .scan_out(scan_out)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        tsvr_group u_grp (
            .clk(clk), .rst(rst), .fuse_load(fuse_load),
            .fuse_bits(fuse_fail_map[g*GRP_PHY +: GRP_PHY]),
            .sig_in(tx_sig[g*GRP_SIG +: GRP_SIG]),
            .link_out(tsv_drive[g*GRP_PHY +: GRP_PHY]),
            .link_in(tsv_sense[g*GRP_PHY +: GRP_PHY]),
            .sig_out(rx_sig[g*GRP_SIG +: GRP_SIG]),
            .unrep(unrepairable[g]),
            .bad_q(bad_q[g*GRP_PHY +: GRP_PHY])
        );
    end
endmodule

// File: rtl/tsvr_checks.sv
`timescale 1ns/1ps
module tsvr_checks
    import tsvr_pkg::*;
#(
    parameter int NGRP = 2,
    localparam int NT  = NGRP * GRP_PHY
) (
    input logic            clk,
    input logic            rst,
    input logic            capture_en,
    input logic [NT-1:0]   open_short_fail,
    input logic            scan_en,
    input logic            scan_in,
    input logic            scan_out,
    input logic            fuse_load,
    input logic [NT-1:0]   fuse_fail_map,
    input logic [NT-1:0]   tsv_drive,
    input logic [NGRP-1:0] unrepairable,
    input logic [NT-1:0]   scan_q,
    input logic [NT-1:0]   bad_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (scan_out == 1'b0 && unrepairable == '0 && bad_q == '0));

    // R2
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> scan_q == $past(open_short_fail));

    // R3
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !capture_en) |=> (scan_q[NT-1] == $past(scan_in) && scan_out == $past(scan_q[1])));

    // R4
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !capture_en) |=> $stable(scan_q));

    // R5
    fuse_take_chk: assert property (@(posedge clk) disable iff (rst)
        fuse_load |=> bad_q == $past(fuse_fail_map));

    // R5
    fuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fuse_load |=> $stable(bad_q));

    // R7
    bad_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tsv_drive & bad_q) == '0);

    for (genvar g = 0; g < NGRP; g++) begin : g_flag
        // R9
        unrep_flag_chk: assert property (@(posedge clk) disable iff (rst)
            unrepairable[g] == ($countones(bad_q[g*GRP_PHY +: GRP_PHY]) > SPARE));
    end
endmodule

bind tsvr_top tsvr_checks #(.NGRP(NGRP)) u_checks (
    .clk(clk), .rst(rst), .capture_en(capture_en), .open_short_fail(open_short_fail),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out), .fuse_load(fuse_load),
    .fuse_fail_map(fuse_fail_map), .tsv_drive(tsv_drive), .unrepairable(unrepairable),
    .scan_q(scan_q), .bad_q(bad_q)
);

// File: tb/test_tsvr_top.sv
`timescale 1ns/1ps
module test_tsvr_top;
    localparam int NGRP = 2;
    localparam int PHY  = 6;
    localparam int SIG  = 4;
    localparam int NT   = NGRP * PHY;
    localparam int NS   = NGRP * SIG;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            capture_en = 1'b0;
    logic [NT-1:0]   open_short_fail = '0;
    logic            scan_en = 1'b0;
    logic            scan_in = 1'b0;
    logic            scan_out;
    logic            fuse_load = 1'b0;
    logic [NT-1:0]   fuse_fail_map = '0;
    logic [NS-1:0]   tx_sig = '0;
    logic [NT-1:0]   tsv_drive;
    logic [NT-1:0]   tsv_sense;
    logic [NS-1:0]   rx_sig;
    logic [NGRP-1:0] unrepairable;
    logic [NT-1:0]   broken = '0;   // physical faults: a broken link inverts its bit

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    assign tsv_sense = tsv_drive ^ broken;

    tsvr_top #(.NGRP(NGRP)) i_tsvr_top (
        .clk(clk), .rst(rst), .capture_en(capture_en), .open_short_fail(open_short_fail),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out), .fuse_load(fuse_load),
        .fuse_fail_map(fuse_fail_map), .tx_sig(tx_sig), .tsv_drive(tsv_drive),
        .tsv_sense(tsv_sense), .rx_sig(rx_sig), .unrepairable(unrepairable)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Expected link drive for one group, from R6/R7.
    function automatic logic [PHY-1:0] exp_links(input logic [PHY-1:0] bad, input logic [SIG-1:0] s);
        logic [PHY-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int p = 0; p < PHY; p++) begin
            if (!bad[p] && k < SIG) begin
                r[p] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    // Expected received signals for one group, from R8/R9.
    function automatic logic [SIG-1:0] exp_rx(input logic [PHY-1:0] bad, input logic [SIG-1:0] s);
        int good;
        logic [SIG-1:0] r;
        good = PHY - $countones(bad);
        for (int i = 0; i < SIG; i++) r[i] = (i < good) ? s[i] : 1'b0;
        return r;
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        tx_sig = 8'h9C;
        #1;
        check(scan_out == 1'b0, "R1 scan_out after reset", 32'(scan_out), 0);
        check(unrepairable == '0, "R1 flags after reset", 32'(unrepairable), 0);
        check(tsv_drive == {2'b00, 4'h9, 2'b00, 4'hC}, "R1 identity drive after reset",
              32'(tsv_drive), 32'({2'b00, 4'h9, 2'b00, 4'hC}));
    endtask

    task automatic test_scan();
        logic [NT-1:0] pat, fill, p2, p3;
        pat  = 12'hB63;
        fill = 12'h5A9;
        open_short_fail = pat;
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
        for (int k = 0; k < NT; k++) begin
            #1;
            check(scan_out == pat[k], "R3 readout order", 32'(scan_out), 32'(pat[k]));
            scan_en = 1'b1;
            scan_in = fill[k];
            tick();
        end
        scan_en = 1'b0;
        for (int k = 0; k < NT; k++) begin
            #1;
            check(scan_out == fill[k], "R3 refill from scan_in", 32'(scan_out), 32'(fill[k]));
            scan_en = 1'b1;
            scan_in = 1'b0;
            tick();
        end
        scan_en = 1'b0;
        // R4 hold: idle cycles must not move the chain
        p2 = 12'h0F2;
        open_short_fail = p2;
        capture_en = 1'b1;
        tick();
        capture_en = 1'b0;
        open_short_fail = '1;
        tick(); tick(); tick();
        check(scan_out == p2[0], "R4 hold bit0", 32'(scan_out), 32'(p2[0]));
        scan_en = 1'b1;
        tick();
        scan_en = 1'b0;
        check(scan_out == p2[1], "R4 hold bit1 after one shift", 32'(scan_out), 32'(p2[1]));
        // R2 capture beats shift
        p3 = 12'h3A5;
        open_short_fail = p3;
        capture_en = 1'b1;
        scan_en = 1'b1;
        tick();
        capture_en = 1'b0;
        check(scan_out == p3[0], "R2 capture priority bit0", 32'(scan_out), 32'(p3[0]));
        tick();
        scan_en = 1'b0;
        check(scan_out == p3[1], "R2 capture priority bit1", 32'(scan_out), 32'(p3[1]));
    endtask

    task automatic load_map(input logic [NT-1:0] m);
        fuse_fail_map = m;
        broken = m;
        fuse_load = 1'b1;
        tick();
        fuse_load = 1'b0;
    endtask

    task automatic test_sweep();
        logic [PHY-1:0] g1 = 6'b100001;
        logic [SIG-1:0] pats [4] = '{4'hF, 4'h5, 4'hA, 4'h6};
        for (int m = 0; m < 64; m++) begin
            load_map({g1, 6'(m)});
            check(unrepairable == {1'b0, ($countones(6'(m)) > 2)}, "R9 flag per map",
                  32'(unrepairable), 32'({1'b0, ($countones(6'(m)) > 2)}));
            for (int d = 0; d < 4; d++) begin
                tx_sig = {pats[3-d], pats[d]};
                #1;
                check(tsv_drive[5:0] == exp_links(6'(m), pats[d]),
                      (m == 0) ? "R6 drive no failures" : "R7 drive shifted",
                      32'(tsv_drive[5:0]), 32'(exp_links(6'(m), pats[d])));
                if ($countones(6'(m)) <= 2)
                    check(rx_sig[3:0] == pats[d], "R8 end-to-end", 32'(rx_sig[3:0]), 32'(pats[d]));
                else
                    check(rx_sig[3:0] == exp_rx(6'(m), pats[d]), "R9 missing lanes read 0",
                          32'(rx_sig[3:0]), 32'(exp_rx(6'(m), pats[d])));
                check(tsv_drive[11:6] == exp_links(g1, pats[3-d]) && rx_sig[7:4] == pats[3-d],
                      "R10 other group untouched", 32'({tsv_drive[11:6], rx_sig[7:4]}),
                      32'({exp_links(g1, pats[3-d]), pats[3-d]}));
            end
        end
    endtask

    task automatic test_fuse_hold();
        load_map({6'b000000, 6'b000100});
        tx_sig = 8'h0B;
        #1;
        check(tsv_drive == 12'(exp_links(6'b000100, 4'hB)), "R5 map loaded",
              32'(tsv_drive), 32'(exp_links(6'b000100, 4'hB)));
        fuse_fail_map = 12'b110000_000011;
        tick();
        tick();
        check(tsv_drive == 12'(exp_links(6'b000100, 4'hB)), "R5 map ignored without load",
              32'(tsv_drive), 32'(exp_links(6'b000100, 4'hB)));
        check(unrepairable == 2'b00, "R5 flag unchanged without load", 32'(unrepairable), 0);
        fuse_load = 1'b1;
        tick();
        fuse_load = 1'b0;
        check(tsv_drive[5:0] == exp_links(6'b000011, 4'hB), "R5 map taken on load",
              32'(tsv_drive[5:0]), 32'(exp_links(6'b000011, 4'hB)));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_scan();
        test_sweep();
        test_fuse_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule